// File: doc/BRIEF.md
# SD Command Issue and Status Unit

This unit is the command half of an SD host controller's register file. Software writes a 32-bit argument and then a 16-bit command word. That write launches the command toward a command-line serializer, and the serializer is reached through a one-cycle start strobe and a one-cycle completion strobe. The unit tracks the two inhibit flags in its present-state word. It captures up to 128 bits of response and raises interrupt status bits, which are enabled per bit and cleared by writing one. A response that does not arrive within a fixed number of card-clock ticks ends the command with a timeout error.

A software-reset register lets firmware abort the command path, the data path, or both at once. Each reset bit reads back as one while its reset is in progress and then clears itself. The data lines report the end of a busy or data phase through a single pulse. CRC generation and the data lines themselves belong to neighbouring blocks.

The command word carries the index in bits [13:8] and a response code in bits [7:0]. In that code, bits [1:0] select the response type: 00 none, 01 136-bit, 10 48-bit, 11 48-bit with busy. Bit 3 asks for a CRC check, bit 4 asks for an index check, and bit 5 marks a data transfer.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset every register reads zero: argument (word 0), command (1), response words (2..5), present state (6, except bit 16), interrupt status (7), interrupt enable (8) and software reset (9).
- R2: Writing word 1 while command inhibit (present-state bit 0) is clear stores the command, raises `ser_start` for exactly one cycle after the write edge with `ser_index` equal to bits [13:8], `ser_code` equal to bits [7:0] and `ser_arg` equal to word 0, and sets command inhibit until the command ends.
- R3: A command write while command inhibit is set is ignored: no `ser_start`, and word 1 keeps its old value.
- R4: A command whose code has bits [1:0]=11 or bit 5 set sets data inhibit (present-state bit 1) at launch and cannot launch while data inhibit is set. Data inhibit clears on a `dat_done` pulse, on a timeout or on a data-path reset. A command without these code bits may launch while data inhibit is set.
- R5: At the end of a response, code type 01 stores all four words from `rsp_data`, with word 2 taking bits [31:0]. Types 10 and 11 store only `rsp_data[31:0]` into word 2. Type 00 stores nothing.
- R6: A `rsp_done` pulse during an inhibited command clears command inhibit and, if no check failed, sets normal status bit 0 (command complete).
- R7: If `card_tick` is seen TIMEOUT_TICKS times while command inhibit stays set, command inhibit clears and error status bit 0 (status word bit 16) is set instead of command complete.
- R8: `rsp_crc_bad` with code bit 3 set raises error bit 1 (word bit 17), and `rsp_idx_bad` with code bit 4 set raises error bit 3 (word bit 19). Either one blocks command complete. A failure report is ignored when the code does not ask for that check.
- R9: Status word bit 15 reads as the OR of all error bits [31:16] and cannot be written.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
- R11: A status bit latches only if the enable bit at the same position in word 8 is set.
- R12: Each software-reset bit written as 1 reads back as 1 for RST_HOLD cycles and then clears itself.
- R13: Reset bit 1 (command path) clears command inhibit, drives `ser_abort` and ignores responses while active. Bit 2 (data path) clears data inhibit and drives `dat_abort`. Bit 0 does both and also clears every register.
- R14: Present-state bit 16 follows `card_present`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| card_present | input | 1 | Card detect level |
| card_tick | input | 1 | One pulse per card clock |
| ser_start | output | 1 | Launch strobe to serializer |
| ser_index | output | 6 | Command index |
| ser_code | output | 8 | Response/flag code |
| ser_arg | output | 32 | Command argument |
| ser_abort | output | 1 | Command path reset active |
| rsp_done | input | 1 | Serializer finished the command |
| rsp_crc_bad | input | 1 | Response CRC failed (with rsp_done) |
| rsp_idx_bad | input | 1 | Response index mismatch (with rsp_done) |
| rsp_data | input | 128 | Received response bits |
| dat_done | input | 1 | Busy/data phase finished |
| dat_abort | output | 1 | Data path reset active |

## Verification
An inhibit flag stuck at one shows up on the next command write: `ser_start` stays low in the following cycle and the command word keeps its old value. An inhibit flag stuck at zero lets a second launch through at once. A timeout counter that is off by one moves the moment present-state bit 0 falls away from exactly TIMEOUT_TICKS ticks after launch, so the bench checks one tick before that point and on it. Errors in status enables or write-one-to-clear handling appear in the status word at the first read after the response edge. Errors in the scope of a reset appear when the inhibit flags are read while that reset runs and when the reset bit is read just before and at its self-clear.

// File: rtl/sdc_pkg.sv
// Shared definitions for the SD command issue unit: register word
// addresses and response-type encodings of the command code.
package sdc_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_ARG   = 4'd0,
        A_CMD   = 4'd1,
        A_RSP0  = 4'd2,
        A_RSP1  = 4'd3,
        A_RSP2  = 4'd4,
        A_RSP3  = 4'd5,
        A_STATE = 4'd6,
        A_ISTAT = 4'd7,
        A_IEN   = 4'd8,
        A_SRST  = 4'd9
    } sdc_addr_e;

    localparam logic [1:0] RT_NONE  = 2'b00;
    localparam logic [1:0] RT_LONG  = 2'b01;
    localparam logic [1:0] RT_SHORT = 2'b10;
    localparam logic [1:0] RT_BUSY  = 2'b11;

    // Code bit positions
    localparam int CB_CRC  = 3;
    localparam int CB_IDX  = 4;
    localparam int CB_DATA = 5;
endpackage

// File: rtl/sdc_sreset.sv
// Self-clearing software reset bits. A write of 1 to a scope bit starts
// (or restarts) a hold of HOLD cycles during which the bit reads as 1.
// Assumes HOLD >= 2. Writes of 0 have no effect.
module sdc_sreset #(
    parameter int SCOPES = 3,
    parameter int HOLD   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [SCOPES-1:0] wdata,
    output logic [SCOPES-1:0] active
);
    localparam int CW = $clog2(HOLD + 1);

    for (genvar g = 0; g < SCOPES; g++) begin : g_scope
        logic [CW-1:0] cnt;

        // Hold counter per scope; the active bit drops after HOLD cycles
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active[g] <= 1'b0;
                cnt       <= '0;
            end else if (wr && wdata[g]) begin
                active[g] <= 1'b1;
                cnt       <= '0;
            end else if (active[g]) begin
                if (cnt == CW'(HOLD - 1)) begin
                    active[g] <= 1'b0;
                    cnt       <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end

        // R12: an idle scope has a parked counter
        p_idle_parked_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !active[g] |-> cnt == '0);
        // R12: a fresh write is visible on the next cycle
        p_write_seen_r12: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && wdata[g]) |=> active[g]);
    end
endmodule

// File: rtl/sdc_int_status.sv
// Normal and error interrupt status with per-bit enable and
// write-one-to-clear. Normal bit NB-1 is a read-only summary of the
// error half. A set in the same cycle as a clear wins.
module sdc_int_status #(
    parameter int NB = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_all,
    input  logic [NB-2:0]   set_norm,
    input  logic [NB-1:0]   set_err,
    input  logic [NB-2:0]   en_norm,
    input  logic [NB-1:0]   en_err,
    input  logic            w1c_wr,
    input  logic [2*NB-2:0] w1c_data,   // {err[NB-1:0], norm[NB-2:0]}
    output logic [2*NB-1:0] status_rd
);
    logic [NB-2:0] norm_q;
    logic [NB-1:0] err_q;

    for (genvar g = 0; g < NB - 1; g++) begin : g_norm
        // Normal status bit: latch on enabled set, drop on write of 1
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)                norm_q[g] <= 1'b0;
            else if (set_norm[g] && en_norm[g])  norm_q[g] <= 1'b1;
            else if (w1c_wr && w1c_data[g])      norm_q[g] <= 1'b0;
        end

        // R11: with enable low a clear bit stays clear
        p_norm_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_norm[g] && !norm_q[g]) |=> !norm_q[g]);
        // R10: a write of 1 with no competing set clears the bit
        p_norm_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (w1c_wr && w1c_data[g] && !set_norm[g]) |=> !norm_q[g]);
    end

    for (genvar g = 0; g < NB; g++) begin : g_err
        // Error status bit: latch on enabled set, drop on write of 1
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all)              err_q[g] <= 1'b0;
            else if (set_err[g] && en_err[g])  err_q[g] <= 1'b1;
            else if (w1c_wr && w1c_data[NB-1+g]) err_q[g] <= 1'b0;
        end

        // R11: with enable low a clear error bit stays clear
        p_err_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_err[g] && !err_q[g]) |=> !err_q[g]);
    end

    // Read view with the error summary in the top normal bit
    always_comb status_rd = {err_q, |err_q, norm_q};

    // R9: summary bit agrees with the error half
    p_summary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd[NB-1] == (status_rd[2*NB-1:NB] != '0));
endmodule

// File: rtl/sdc_cmd_ctrl.sv
// Command launch and completion tracking: command and data inhibit,
// the response timeout counted in card ticks, and the start strobe.
// Assumes rsp_done and card_tick are single-cycle pulses.
module sdc_cmd_ctrl #(
    parameter int TIMEOUT_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_rst,
    input  logic dat_rst,
    input  logic launch_req,
    input  logic launch_needs_dat,
    input  logic card_tick,
    input  logic rsp_done,
    input  logic dat_done,
    output logic cmd_inh,
    output logic dat_inh,
    output logic launch_ok,
    output logic ser_start,
    output logic rsp_end,
    output logic timeout_hit
);
    localparam int TO_W = $clog2(TIMEOUT_TICKS);

    logic [TO_W-1:0] to_cnt;

    // Launch acceptance and the two command outcomes
    always_comb begin
        launch_ok   = launch_req && !cmd_inh && !cmd_rst
                      && !(launch_needs_dat && dat_inh);
        rsp_end     = rsp_done && cmd_inh && !cmd_rst;
        timeout_hit = cmd_inh && !cmd_rst && !rsp_done && card_tick
                      && (to_cnt == TO_W'(TIMEOUT_TICKS - 1));
    end

    // Command inhibit: set on launch, cleared by response, timeout or reset
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_rst)          cmd_inh <= 1'b0;
        else if (launch_ok)             cmd_inh <= 1'b1;
        else if (rsp_end || timeout_hit) cmd_inh <= 1'b0;
    end

    // Data inhibit: set by busy/data commands, cleared by the data side
    always_ff @(posedge clk) begin
        if (!rst_n || dat_rst)                 dat_inh <= 1'b0;
        else if (launch_ok && launch_needs_dat) dat_inh <= 1'b1;
        else if (dat_done || timeout_hit)      dat_inh <= 1'b0;
    end

    // Timeout counter of card ticks while a command is outstanding
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_rst || launch_ok)       to_cnt <= '0;
        else if (cmd_inh && card_tick && !timeout_hit) to_cnt <= to_cnt + 1'b1;
    end

    // One-cycle start strobe toward the serializer
    always_ff @(posedge clk) begin
        if (!rst_n) ser_start <= 1'b0;
        else        ser_start <= launch_ok;
    end

    // R2: a start strobe always comes with the command held inhibited
    p_start_inhibited_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ser_start |-> cmd_inh);
    // R3: a write during inhibit produces no start
    p_busy_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && cmd_inh) |=> !ser_start);
    // R4: a data-needing command is held off by data inhibit
    p_dat_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_req && launch_needs_dat && dat_inh) |=> !ser_start);
    // R7: a timeout releases the command line
    p_timeout_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |=> !cmd_inh);
    // R6: response end and timeout never coincide
    p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_end && timeout_hit));
    // R13: command reset leaves the line free on the next cycle
    p_cmd_reset_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rst |=> !cmd_inh);
endmodule

// File: rtl/sd_cmd_issue.sv
// SD command issue and status unit. Register decode, argument/command
// storage, response capture, and wiring of the inhibit, status and
// software-reset sub-blocks. Reads are combinational from bus_addr;
// writes take effect on the clock edge where bus_wr is high.
module sd_cmd_issue
    import sdc_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 64,
    parameter int RST_HOLD      = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic [3:0]   bus_addr,
    input  logic [31:0]  bus_wdata,
    output logic [31:0]  bus_rdata,
    input  logic         card_present,
    input  logic         card_tick,
    output logic         ser_start,
    output logic [5:0]   ser_index,
    output logic [7:0]   ser_code,
    output logic [31:0]  ser_arg,
    output logic         ser_abort,
    input  logic         rsp_done,
    input  logic         rsp_crc_bad,
    input  logic         rsp_idx_bad,
    input  logic [127:0] rsp_data,
    input  logic         dat_done,
    output logic         dat_abort
);
    localparam int NB      = 16;
    localparam int RWORDS  = 4;
    localparam int SCOPES  = 3;

    logic [31:0]        arg_q;
    logic [15:0]        cmd_q;
    logic [31:0]        rsp_q [RWORDS];
    logic [31:0]        ien_q;
    logic [SCOPES-1:0]  srst_act;
    logic               all_rst, cmd_rst, dat_rst;
    logic               wr_arg, wr_cmd, wr_istat, wr_ien, wr_srst;
    logic               new_needs_dat;
    logic               cmd_inh, dat_inh, launch_ok, rsp_end, timeout_hit;
    logic               crc_fail, idx_fail;
    logic [NB-2:0]      set_norm;
    logic [NB-1:0]      set_err;
    logic [2*NB-1:0]    status_rd;

    // Write strobes per register word
    always_comb begin
        wr_arg   = bus_wr && (bus_addr == A_ARG);
        wr_cmd   = bus_wr && (bus_addr == A_CMD);
        wr_istat = bus_wr && (bus_addr == A_ISTAT);
        wr_ien   = bus_wr && (bus_addr == A_IEN);
        wr_srst  = bus_wr && (bus_addr == A_SRST);
    end

    // Reset scopes: bit 0 covers both paths and the registers
    always_comb begin
        all_rst   = srst_act[0];
        cmd_rst   = srst_act[0] | srst_act[1];
        dat_rst   = srst_act[0] | srst_act[2];
        ser_abort = cmd_rst;
        dat_abort = dat_rst;
    end

    // Decode of the code bits that need the data side
    always_comb new_needs_dat = (bus_wdata[1:0] == RT_BUSY) || bus_wdata[CB_DATA];

    sdc_sreset #(.SCOPES(SCOPES), .HOLD(RST_HOLD)) u_srst (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (wr_srst),
        .wdata  (bus_wdata[SCOPES-1:0]),
        .active (srst_act)
    );

    sdc_cmd_ctrl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_rst          (cmd_rst),
        .dat_rst          (dat_rst),
        .launch_req       (wr_cmd),
        .launch_needs_dat (new_needs_dat),
        .card_tick        (card_tick),
        .rsp_done         (rsp_done),
        .dat_done         (dat_done),
        .cmd_inh          (cmd_inh),
        .dat_inh          (dat_inh),
        .launch_ok        (launch_ok),
        .ser_start        (ser_start),
        .rsp_end          (rsp_end),
        .timeout_hit      (timeout_hit)
    );

    // Argument register
    always_ff @(posedge clk) begin
        if (!rst_n || all_rst) arg_q <= '0;
        else if (wr_arg)       arg_q <= bus_wdata;
    end

    // Command register: only an accepted launch updates it
    always_ff @(posedge clk) begin
        if (!rst_n || all_rst) cmd_q <= '0;
        else if (launch_ok)    cmd_q <= bus_wdata[15:0];
    end

    // Interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n || all_rst) ien_q <= '0;
        else if (wr_ien)       ien_q <= bus_wdata;
    end

    // Response capture, one word per generate step
    for (genvar w = 0; w < RWORDS; w++) begin : g_rsp
        logic take;
        always_comb begin
            if (w == 0) take = rsp_end && (cmd_q[1:0] != RT_NONE);
            else        take = rsp_end && (cmd_q[1:0] == RT_LONG);
        end
        // Response word w storage
        always_ff @(posedge clk) begin
            if (!rst_n || all_rst) rsp_q[w] <= '0;
            else if (take)         rsp_q[w] <= rsp_data[32*w +: 32];
        end
    end

    // Check failures of the response that just ended
    always_comb begin
        crc_fail = rsp_end && cmd_q[CB_CRC] && rsp_crc_bad;
        idx_fail = rsp_end && cmd_q[CB_IDX] && rsp_idx_bad;
        set_norm = '0;
        set_norm[0] = rsp_end && !crc_fail && !idx_fail;
        set_err = '0;
        set_err[0] = timeout_hit;
        set_err[1] = crc_fail;
        set_err[3] = idx_fail;
    end

    sdc_int_status #(.NB(NB)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_all   (all_rst),
        .set_norm  (set_norm),
        .set_err   (set_err),
        .en_norm   (ien_q[NB-2:0]),
        .en_err    (ien_q[2*NB-1:NB]),
        .w1c_wr    (wr_istat),
        .w1c_data  ({bus_wdata[2*NB-1:NB], bus_wdata[NB-2:0]}),
        .status_rd (status_rd)
    );

    // Serializer-facing command fields
    always_comb begin
        ser_index = cmd_q[13:8];
        ser_code  = cmd_q[7:0];
        ser_arg   = arg_q;
    end

    // Read multiplexer
    always_comb begin
        unique case (bus_addr)
            A_ARG:   bus_rdata = arg_q;
            A_CMD:   bus_rdata = {16'h0, cmd_q};
            A_RSP0:  bus_rdata = rsp_q[0];
            A_RSP1:  bus_rdata = rsp_q[1];
            A_RSP2:  bus_rdata = rsp_q[2];
            A_RSP3:  bus_rdata = rsp_q[3];
            A_STATE: bus_rdata = {15'h0, card_present, 14'h0, dat_inh, cmd_inh};
            A_ISTAT: bus_rdata = status_rd;
            A_IEN:   bus_rdata = ien_q;
            A_SRST:  bus_rdata = {{(32-SCOPES){1'b0}}, srst_act};
            default: bus_rdata = '0;
        endcase
    end

    // R5: a no-response command leaves the first response word alone
    p_none_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n || all_rst)
        (rsp_end && cmd_q[1:0] == RT_NONE) |=> $stable(rsp_q[0]));
    // R3: a refused write leaves the command word unchanged
    p_cmd_kept_r3: assert property (@(posedge clk) disable iff (!rst_n || all_rst)
        (wr_cmd && cmd_inh) |=> $stable(cmd_q));
    // R13: responses during a command reset raise no completion
    p_reset_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rst && !all_rst) |=> !($rose(status_rd[0])));
endmodule

// File: tb/sd_cmd_issue_test.sv
module sd_cmd_issue_test;
    localparam int TO   = 64;
    localparam int HOLD = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         card_present = 1'b0;
    logic         card_tick = 1'b0;
    logic         ser_start;
    logic [5:0]   ser_index;
    logic [7:0]   ser_code;
    logic [31:0]  ser_arg;
    logic         ser_abort;
    logic         rsp_done = 1'b0;
    logic         rsp_crc_bad = 1'b0;
    logic         rsp_idx_bad = 1'b0;
    logic [127:0] rsp_data = '0;
    logic         dat_done = 1'b0;
    logic         dat_abort;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sd_cmd_issue #(.TIMEOUT_TICKS(TO), .RST_HOLD(HOLD)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_present(card_present), .card_tick(card_tick),
        .ser_start(ser_start), .ser_index(ser_index), .ser_code(ser_code),
        .ser_arg(ser_arg), .ser_abort(ser_abort), .rsp_done(rsp_done),
        .rsp_crc_bad(rsp_crc_bad), .rsp_idx_bad(rsp_idx_bad),
        .rsp_data(rsp_data), .dat_done(dat_done), .dat_abort(dat_abort)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic bw(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rchk(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v); chk(req, v, exp);
    endtask

    task automatic respond(input logic [127:0] d, input logic crc, input logic idx);
        rsp_done = 1'b1; rsp_data = d; rsp_crc_bad = crc; rsp_idx_bad = idx;
        @(posedge clk); @(negedge clk);
        rsp_done = 1'b0; rsp_crc_bad = 1'b0; rsp_idx_bad = 1'b0;
    endtask

    task automatic pulse_dat_done();
        dat_done = 1'b1; @(posedge clk); @(negedge clk); dat_done = 1'b0;
    endtask

    task automatic t_reset();
        rchk("R1 arg", 4'd0, 32'h0);
        rchk("R1 cmd", 4'd1, 32'h0);
        rchk("R1 rsp0", 4'd2, 32'h0);
        rchk("R1 rsp3", 4'd5, 32'h0);
        rchk("R1 state", 4'd6, 32'h0);
        rchk("R1 istat", 4'd7, 32'h0);
        rchk("R1 ien", 4'd8, 32'h0);
        rchk("R1 srst", 4'd9, 32'h0);
        chk("R1 ser_start", {31'h0, ser_start}, 32'h0);
        card_present = 1'b1; #1;
        rchk("R14 card bit", 4'd6, 32'h0001_0000);
    endtask

    task automatic t_launch_short();
        logic [31:0] v;
        bw(4'd0, 32'h1234_5678);
        bw(4'd1, 32'h0000_111A);
        chk("R2 start", {31'h0, ser_start}, 32'h1);
        chk("R2 index", {26'h0, ser_index}, 32'd17);
        chk("R2 code", {24'h0, ser_code}, 32'h1A);
        chk("R2 arg", ser_arg, 32'h1234_5678);
        rchk("R2 inhibit", 4'd6, 32'h0001_0001);
        bw(4'd1, 32'h0000_0909);
        chk("R3 no start", {31'h0, ser_start}, 32'h0);
        rchk("R3 cmd kept", 4'd1, 32'h0000_111A);
        respond({32'h4444_4444, 32'h3333_3333, 32'h2222_2222, 32'h1111_1111}, 1'b0, 1'b0);
        rchk("R5 short w0", 4'd2, 32'h1111_1111);
        rchk("R5 short w1", 4'd3, 32'h0);
        rchk("R6 complete", 4'd7, 32'h0000_0001);
        rd(4'd6, v); chk("R6 inhibit clear", v & 32'h3, 32'h0);
        bw(4'd7, 32'h0000_0000);
        rchk("R10 zero write", 4'd7, 32'h0000_0001);
        bw(4'd7, 32'h0000_0001);
        rchk("R10 one write", 4'd7, 32'h0);
    endtask

    task automatic t_long_none();
        bw(4'd1, 32'h0000_0209);
        respond({32'hD0D0_0003, 32'hC0C0_0002, 32'hB0B0_0001, 32'hA0A0_0000}, 1'b0, 1'b0);
        rchk("R5 long w0", 4'd2, 32'hA0A0_0000);
        rchk("R5 long w1", 4'd3, 32'hB0B0_0001);
        rchk("R5 long w2", 4'd4, 32'hC0C0_0002);
        rchk("R5 long w3", 4'd5, 32'hD0D0_0003);
        bw(4'd7, 32'hFFFF_FFFF);
        bw(4'd1, 32'h0000_0000);
        respond({4{32'hFFFF_FFFF}}, 1'b0, 1'b0);
        rchk("R5 none keeps", 4'd2, 32'hA0A0_0000);
        rchk("R6 none complete", 4'd7, 32'h1);
        bw(4'd7, 32'hFFFF_FFFF);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        bw(4'd1, 32'h0000_071B);
        rd(4'd6, v); chk("R4 both inhibits", v & 32'h3, 32'h3);
        respond('0, 1'b0, 1'b0);
        rd(4'd6, v); chk("R4 data inhibit stays", v & 32'h3, 32'h2);
        bw(4'd1, 32'h0000_193A);
        chk("R4 data cmd blocked", {31'h0, ser_start}, 32'h0);
        rchk("R4 cmd kept", 4'd1, 32'h0000_071B);
        bw(4'd1, 32'h0000_0D1A);
        chk("R4 plain cmd allowed", {31'h0, ser_start}, 32'h1);
        respond('0, 1'b0, 1'b0);
        pulse_dat_done();
        rd(4'd6, v); chk("R4 dat_done clears", v & 32'h3, 32'h0);
        bw(4'd7, 32'hFFFF_FFFF);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        bw(4'd1, 32'h0000_0102);
        card_tick = 1'b1;
        repeat (TO - 1) @(posedge clk);
        @(negedge clk);
        rd(4'd6, v); chk("R7 still waiting", v & 32'h1, 32'h1);
        @(posedge clk); @(negedge clk);
        card_tick = 1'b0;
        rd(4'd6, v); chk("R7 released", v & 32'h1, 32'h0);
        rchk("R7 R9 timeout status", 4'd7, 32'h0001_8000);
        bw(4'd7, 32'h0000_8000);
        rchk("R9 summary not writable", 4'd7, 32'h0001_8000);
        bw(4'd7, 32'h0001_0000);
        rchk("R9 summary follows", 4'd7, 32'h0);
    endtask

    task automatic t_checks();
        bw(4'd1, 32'h0000_111A);
        respond('0, 1'b1, 1'b0);
        rchk("R8 crc error", 4'd7, 32'h0002_8000);
        bw(4'd7, 32'hFFFF_FFFF);
        bw(4'd1, 32'h0000_111A);
        respond('0, 1'b0, 1'b1);
        rchk("R8 index error", 4'd7, 32'h0008_8000);
        bw(4'd7, 32'hFFFF_FFFF);
        bw(4'd1, 32'h0000_2902);
        respond('0, 1'b1, 1'b1);
        rchk("R8 unchecked code", 4'd7, 32'h0000_0001);
        bw(4'd7, 32'hFFFF_FFFF);
    endtask

    task automatic t_enable();
        bw(4'd8, 32'h0);
        bw(4'd1, 32'h0000_111A);
        respond('0, 1'b1, 1'b0);
        rchk("R11 disabled error", 4'd7, 32'h0);
        bw(4'd1, 32'h0000_111A);
        respond('0, 1'b0, 1'b0);
        rchk("R11 disabled complete", 4'd7, 32'h0);
        bw(4'd8, 32'hFFFF_FFFF);
    endtask

    task automatic t_sreset();
        logic [31:0] v;
        bw(4'd1, 32'h0000_111A);
        bw(4'd9, 32'h2);
        rchk("R12 reads one", 4'd9, 32'h2);
        chk("R13 ser_abort", {31'h0, ser_abort}, 32'h1);
        respond('0, 1'b0, 1'b0);
        rd(4'd6, v); chk("R13 cmd inhibit cleared", v & 32'h1, 32'h0);
        rchk("R13 response ignored", 4'd7, 32'h0);
        repeat (HOLD - 2) @(posedge clk);
        @(negedge clk);
        rchk("R12 still held", 4'd9, 32'h2);
        @(posedge clk); @(negedge clk);
        rchk("R12 self cleared", 4'd9, 32'h0);
        bw(4'd1, 32'h0000_071B);
        respond('0, 1'b0, 1'b0);
        bw(4'd9, 32'h4);
        chk("R13 dat_abort", {31'h0, dat_abort}, 32'h1);
        repeat (HOLD) @(posedge clk);
        @(negedge clk);
        rd(4'd6, v); chk("R13 data inhibit cleared", v & 32'h3, 32'h0);
        bw(4'd7, 32'hFFFF_FFFF);
        bw(4'd0, 32'hCAFE_0001);
        bw(4'd9, 32'h1);
        repeat (HOLD) @(posedge clk);
        @(negedge clk);
        rchk("R13 all clears arg", 4'd0, 32'h0);
        rchk("R13 all clears ien", 4'd8, 32'h0);
        rchk("R13 all clears rsp", 4'd2, 32'h0);
        rchk("R13 all clears cmd", 4'd1, 32'h0);
    endtask

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        bw(4'd8, 32'hFFFF_FFFF);
        t_launch_short();
        t_long_none();
        t_busy();
        t_timeout();
        t_checks();
        t_enable();
        t_sreset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule